// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a vector of level-sensitive interrupt request lines and chooses one of them to present to a processor core. Each source has an enable bit and a two-bit priority level. A request competes only if its level reaches both the core's two-bit mask and the level of the interrupt already in service, so higher levels can nest on top of lower ones. Among the eligible requests the highest level wins, and ties go to the lowest source number. The winner's vector number and handler address are registered. They stay on the outputs until the core acknowledges them. At that point the in-service status field takes on the accepted level.

Normal handler addresses are computed from a programmable vector base. Two fast-interrupt slots each hold a vector number and a full handler address. When the winner is at level 2 and its number matches a slot, the slot's address is presented directly and a fast flag is raised. The core restores the in-service status on return by writing the status register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: With in-service status 00, a lone enabled request at level L is presented only when L is numerically at least `core_mask` (mask 00 admits 0–3, 01 admits 1–3, 10 admits 2–3, 11 admits 3 only).
- R2: A request is presented only when its level is numerically at least `cur_status`. Status 01 blocks level 0, status 10 blocks levels 0–1, and status 11 blocks levels 0–2. This applies with mask 00.
- R3: On an acknowledge of a presented request, `cur_status` becomes 01 for level 0, 10 for level 1, and 11 for level 2 or 3. After reset it is 00.
- R4: When several eligible requests are pending, the highest level is chosen, and among equal levels the lowest source number is chosen.
- R5: `irq_req`, `irq_vec` and `irq_addr` hold their values until `irq_ack` is pulsed, even if the line drops or a higher request arrives. `irq_req` falls in the cycle after the acknowledge. An acknowledge with no request pending changes nothing.
- R6: A source whose enable bit is 0 never causes a request, at any level.
- R7: A winner at level 2 whose vector equals a fast slot's match register is presented with `irq_fast`=1 and `irq_addr` = {slot high, slot low}.
- R8: Every other winner, including a matching vector at a level other than 2, gets `irq_fast`=0 and `irq_addr` = zero-extended (base + 2 × vector).
- R9: If both fast slots hold the same vector, slot 0's address is used.
- R10: Register map on `cfg_addr`, with 16-bit write data:
  - addresses 0..N_SRC-1 configure the sources: bit 2 is the enable and bits 1:0 the level;
  - N_SRC is the vector base;
  - N_SRC+1 and N_SRC+2 are the match registers of slots 0 and 1;
  - N_SRC+3 and N_SRC+4 are slot 0's low and high address;
  - N_SRC+5 and N_SRC+6 are slot 1's low and high address;
  - N_SRC+7 writes `cur_status` from bits 1:0.
  
  An acknowledge in the same cycle takes precedence over a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(N_SRC+8) | Register address |
| cfg_wdata | input | DW | Register write data |
| irq_in | input | N_SRC | Interrupt request lines |
| core_mask | input | 2 | Core interrupt mask level |
| irq_ack | input | 1 | Core acknowledge pulse |
| irq_req | output | 1 | Interrupt request to core |
| irq_vec | output | $clog2(N_SRC) | Presented vector number |
| irq_addr | output | 2*DW | Presented handler address |
| irq_fast | output | 1 | Presented interrupt uses a fast slot |
| cur_status | output | 2 | In-service level status |

## Verification
The hardest situation to reach is a fast slot colliding with the normal path. This means a matching vector at a non-fast level, or both slots holding one vector, while the in-service status still gates the request. The bench reaches it by sweeping every source through every level, enable value and mask with the two slots pointed at fixed sources. It then repoints both slots at one source. The nesting thresholds are reached by writing the status register directly before each probe, rather than by stacking real acknowledges.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC = 16,
  parameter int DW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(N_SRC+8)-1:0]   cfg_addr,
  input  logic [DW-1:0]                cfg_wdata,
  input  logic [N_SRC-1:0]             irq_in,
  input  logic [1:0]                   core_mask,
  input  logic                         irq_ack,
  output logic                         irq_req,
  output logic [$clog2(N_SRC)-1:0]     irq_vec,
  output logic [2*DW-1:0]              irq_addr,
  output logic                         irq_fast,
  output logic [1:0]                   cur_status
);
  localparam int VW = $clog2(N_SRC);
  localparam int AW = $clog2(N_SRC+8);
  localparam int A_BASE = N_SRC;
  localparam int A_CUR  = N_SRC + 7;

  logic [N_SRC-1:0] en;
  logic [1:0]       lvl [N_SRC];
  logic [DW-1:0]    base;
  logic [VW-1:0]    fmatch [2];
  logic [DW-1:0]    flo [2];
  logic [DW-1:0]    fhi [2];
  logic [1:0]       status;

  logic             req_q, fast_q;
  logic [VW-1:0]    vec_q;
  logic [2*DW-1:0]  addr_q;
  logic [1:0]       plev_q;

  logic             win_ok;
  logic [VW-1:0]    win_vec;
  logic [1:0]       win_lvl;
  logic [1:0]       thr;
  logic             m0, m1;
  logic [2*DW-1:0]  win_addr;

  assign thr = (core_mask > status) ? core_mask : status;

  always_comb begin
    win_ok  = 1'b0;
    win_vec = '0;
    win_lvl = '0;
    for (int i = N_SRC-1; i >= 0; i--) begin
      if (irq_in[i] && en[i] && lvl[i] >= thr && (!win_ok || lvl[i] >= win_lvl)) begin
        win_ok  = 1'b1;
        win_vec = VW'(i);
        win_lvl = lvl[i];
      end
    end
  end

  assign m0 = (win_lvl == 2'd2) && (fmatch[0] == win_vec);
  assign m1 = (win_lvl == 2'd2) && (fmatch[1] == win_vec);
  assign win_addr = m0 ? {fhi[0], flo[0]} :
                    m1 ? {fhi[1], flo[1]} :
                         {{DW{1'b0}}, base + (DW'(win_vec) << 1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      base <= '0;
      for (int i = 0; i < N_SRC; i++) lvl[i] <= '0;
      for (int k = 0; k < 2; k++) begin
        fmatch[k] <= '0;
        flo[k]    <= '0;
        fhi[k]    <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < N_SRC; i++)
        if (cfg_addr == AW'(i)) begin
          en[i]  <= cfg_wdata[2];
          lvl[i] <= cfg_wdata[1:0];
        end
      if (cfg_addr == AW'(A_BASE))   base      <= cfg_wdata;
      if (cfg_addr == AW'(A_BASE+1)) fmatch[0] <= cfg_wdata[VW-1:0];
      if (cfg_addr == AW'(A_BASE+2)) fmatch[1] <= cfg_wdata[VW-1:0];
      if (cfg_addr == AW'(A_BASE+3)) flo[0]    <= cfg_wdata;
      if (cfg_addr == AW'(A_BASE+4)) fhi[0]    <= cfg_wdata;
      if (cfg_addr == AW'(A_BASE+5)) flo[1]    <= cfg_wdata;
      if (cfg_addr == AW'(A_BASE+6)) fhi[1]    <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      fast_q <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
      plev_q <= '0;
      status <= '0;
    end else if (req_q) begin
      if (irq_ack) begin
        req_q  <= 1'b0;
        status <= (plev_q == 2'd0) ? 2'd1 : (plev_q == 2'd1) ? 2'd2 : 2'd3;
      end else if (cfg_we && cfg_addr == AW'(A_CUR)) begin
        status <= cfg_wdata[1:0];
      end
    end else begin
      if (cfg_we && cfg_addr == AW'(A_CUR)) status <= cfg_wdata[1:0];
      if (win_ok) begin
        req_q  <= 1'b1;
        vec_q  <= win_vec;
        addr_q <= win_addr;
        fast_q <= m0 | m1;
        plev_q <= win_lvl;
      end
    end
  end

  assign irq_req    = req_q;
  assign irq_vec    = vec_q;
  assign irq_addr   = addr_q;
  assign irq_fast   = fast_q & req_q;
  assign cur_status = status;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       ack,
  input logic       fast,
  input logic [1:0] mask,
  input logic [1:0] status,
  input logic [1:0] plev,
  input logic [7:0] vec_lo,
  input logic [7:0] addr_lo
);
  p_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> plev >= $past(mask));
  p_nest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> plev >= $past(status));
  p_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req && ack |=> status != 2'd0);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(vec_lo) && $stable(addr_lo));
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req && ack |=> !req);
  p_fast_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req && fast |-> plev == 2'd2);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(irq_req), .ack(irq_ack), .fast(irq_fast),
  .mask(core_mask), .status(cur_status), .plev(plev_q),
  .vec_lo(8'(irq_vec)), .addr_lo(irq_addr[7:0])
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int PERIOD = 10;
  localparam int N = 16;
  localparam int AWB = $clog2(N+8);
  localparam logic [15:0] BASE = 16'h4000;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, irq_ack = 1'b0;
  logic [AWB-1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [N-1:0] irq_in = '0;
  logic [1:0] core_mask = '0;
  logic irq_req, irq_fast;
  logic [3:0] irq_vec;
  logic [31:0] irq_addr;
  logic [1:0] cur_status;
  int checks = 0, fails = 0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_in(irq_in), .core_mask(core_mask),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_addr(irq_addr), .irq_fast(irq_fast), .cur_status(cur_status));

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AWB'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic present(input logic [N-1:0] v, input logic [1:0] m);
    @(negedge clk);
    irq_in = v; core_mask = m;
    @(negedge clk);
  endtask

  task automatic release_req();
    if (irq_req) begin
      irq_ack = 1'b1; irq_in = '0;
      @(negedge clk);
      irq_ack = 1'b0;
    end else irq_in = '0;
  endtask

  function automatic logic [1:0] enc(input int l);
    return (l == 0) ? 2'd1 : (l == 1) ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [31:0] exp_addr(input int v, input int l);
    if (l == 2 && v == 5) return 32'hA5A5_1111;
    if (l == 2 && v == 9) return 32'hB6B6_2222;
    return {16'h0, BASE + 16'(2*v)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_req == 0 && cur_status == 0 && irq_fast == 0, "R3 reset state", {irq_req, cur_status}, 0);
    rst_n = 1'b1;
    // R10: register map configuration
    wr(N, BASE);
    wr(N+1, 5); wr(N+3, 16'h1111); wr(N+4, 16'hA5A5);
    wr(N+2, 9); wr(N+5, 16'h2222); wr(N+6, 16'hB6B6);

    // R1 R6 R3 R7 R8 sweep
    for (int i = 0; i < N; i++)
      for (int l = 0; l < 4; l++)
        for (int e = 0; e < 2; e++)
          for (int m = 0; m < 4; m++) begin
            bit expr;
            wr(i, e*4 + l);
            present(N'(1) << i, 2'(m));
            expr = (e == 1) && (l >= m);
            chk(irq_req == expr, e ? "R1 mask gating" : "R6 disabled source", irq_req, expr);
            if (expr) begin
              chk(irq_vec == 4'(i), "R1 vector", irq_vec, i);
              chk(irq_addr == exp_addr(i, l), (l == 2 && (i == 5 || i == 9)) ? "R7 fast addr" : "R8 normal addr",
                  irq_addr, exp_addr(i, l));
              chk(irq_fast == (l == 2 && (i == 5 || i == 9)), "R7 fast flag", irq_fast, 0);
            end
            release_req();
            chk(irq_req == 0, "R5 drop after ack", irq_req, 0);
            chk(cur_status == (expr ? enc(l) : 2'd0), "R3 status encoding", cur_status, expr ? enc(l) : 0);
            wr(N+7, 0);
            wr(i, 0);
          end

    // R2 nesting threshold
    for (int st = 0; st < 4; st++)
      for (int l = 0; l < 4; l++) begin
        bit expr;
        wr(3, 4 + l);
        wr(N+7, st);
        present(N'(1) << 3, 2'd0);
        expr = l >= st;
        chk(irq_req == expr, "R2 nesting", irq_req, expr);
        release_req();
        wr(N+7, 0);
        wr(3, 0);
      end

    // R4 arbitration over pairs
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        if (a != b) begin
          int la, lb, w;
          la = (a*7 + b) % 4;
          lb = (b*5 + a*3) % 4;
          wr(a, 4 + la); wr(b, 4 + lb);
          present((N'(1) << a) | (N'(1) << b), 2'd0);
          w = (la > lb) ? a : (lb > la) ? b : ((a < b) ? a : b);
          chk(irq_req && irq_vec == 4'(w), "R4 arbitration", irq_vec, w);
          release_req();
          wr(N+7, 0); wr(a, 0); wr(b, 0);
        end

    // R9 both slots same vector
    wr(N+1, 6); wr(N+2, 6); wr(6, 4 + 2);
    present(N'(1) << 6, 2'd0);
    chk(irq_fast == 1 && irq_addr == 32'hA5A5_1111, "R9 slot0 precedence", irq_addr, 32'hA5A5_1111);
    release_req();
    wr(N+7, 0); wr(6, 0);

    // R5 hold until acknowledge
    wr(2, 4 + 1); wr(4, 4 + 3);
    present(N'(1) << 2, 2'd0);
    irq_in = '0;
    @(negedge clk); @(negedge clk);
    chk(irq_req == 1 && irq_vec == 2, "R5 hold after line drops", irq_vec, 2);
    irq_in = N'(1) << 4;
    @(negedge clk); @(negedge clk);
    chk(irq_req == 1 && irq_vec == 2 && irq_addr == {16'h0, BASE + 16'd4}, "R5 hold against higher", irq_vec, 2);
    irq_in = '0; irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(irq_req == 0 && cur_status == 2'd2, "R5 ack clears request", {irq_req, cur_status}, 2);
    wr(N+7, 0);
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(irq_req == 0 && cur_status == 0, "R5 stray ack ignored", cur_status, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule